// File: doc/BRIEF.md
# Capture Input Noise Filter

This block cleans up a raw, asynchronous capture input before a timer acts on it. The input is first brought into the timer clock domain by a synchronizer chain. A run-length counter then watches the synchronized samples: the filtered level changes only once the input has shown the new value for a required number of samples in a row. Any sample that matches the present filtered level cancels the run that is in progress.

A 4-bit filter code sets both the sample rate and the run length. Code 0 turns filtering off: samples are taken only on cycles where the slower, dead-time-scaled sample enable is high, and one sample is enough to change the level. Codes 1, 2 and 3 sample on every timer clock and need runs of 2, 4 and 8 samples. Every higher code behaves like code 3. Whenever the filtered level changes, a one-cycle pulse on the rising or falling strobe marks the direction of the change, in the same cycle as the new level.

Top module: `capture_noise_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `filt_level`, `rise_pulse` and `fall_pulse` are 0 after that edge.
- R2: The raw input passes through two synchronizer flops. With code 0 and `dts_tick` held high, a change of `din_async` that is set up before edge k shows on `filt_level` after edge k+2 and not earlier.
- R3: With code 0, a sample is taken only at edges where `dts_tick` is 1, and a single sample that differs from `filt_level` changes it. At edges where `dts_tick` is 0, `filt_level` holds.
- R4: With code 1, a sample is taken at every edge and 2 consecutive differing samples are needed to change `filt_level`.
- R5: With code 2, a sample is taken at every edge and 4 consecutive differing samples are needed.
- R6: With code 3, a sample is taken at every edge and 8 consecutive differing samples are needed.
- R7: Codes 4 to 15 behave exactly like code 3: sampling at every edge with runs of 8; `dts_tick` has no effect on them.
- R8: A sample equal to the current `filt_level` clears the run count, so a run broken by one agreeing sample must start again from zero.
- R9: `rise_pulse` is 1 for exactly one cycle, the first cycle in which `filt_level` is 1 after being 0, and 0 otherwise.
- R10: `fall_pulse` is 1 for exactly one cycle, the first cycle in which `filt_level` is 0 after being 1, and 0 otherwise; the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| din_async | input | 1 | Raw capture input, asynchronous to `clk` |
| dts_tick | input | 1 | Dead-time-scaled sample enable, used by code 0 only |
| flt_code | input | 4 | Filter code: sample rate and run length |
| filt_level | output | 1 | Filtered input level |
| rise_pulse | output | 1 | One-cycle strobe on a 0 to 1 change of `filt_level` |
| fall_pulse | output | 1 | One-cycle strobe on a 1 to 0 change of `filt_level` |

## Verification
The hardest case to reach is a run that falls exactly one sample short, or is broken by a single agreeing sample just before it would complete, since the output then must not move at all. The stimulus drives pulse trains whose high widths step through N-1, N and N+1 for every code, plus a pattern of seven differing samples, one agreeing sample and seven more, so that a counter that fails to clear or compares off by one changes the level where the reference model does not. A randomized stretch that also changes the code in the middle of runs then checks the same rules under mixed conditions.

// File: rtl/cnf_pkg.sv
package cnf_pkg;
  localparam int unsigned CNF_CODE_W  = 4;
  localparam int unsigned CNF_MAX_RUN = 8;

  // Run length needed by each filter code; every code above 3 uses the longest run.
  function automatic int unsigned cnf_run_of_code(input logic [CNF_CODE_W-1:0] code);
    case (code)
      4'd0:    return 1;
      4'd1:    return 2;
      4'd2:    return 4;
      default: return CNF_MAX_RUN;
    endcase
  endfunction
endpackage

// File: rtl/cnf_sync.sv
module cnf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/cnf_sample_ctrl.sv
module cnf_sample_ctrl
  import cnf_pkg::*;
#(
  parameter int unsigned CODE_W  = CNF_CODE_W,
  parameter int unsigned MAX_RUN = CNF_MAX_RUN,
  localparam int unsigned RUN_W  = $clog2(MAX_RUN + 1)
) (
  input  logic              dts_tick,
  input  logic [CODE_W-1:0] code,
  output logic              smp_en,
  output logic [RUN_W-1:0]  run_n
);
  always_comb begin
    run_n  = RUN_W'(cnf_run_of_code(4'(code)));
    smp_en = (code == '0) ? dts_tick : 1'b1;
  end
endmodule

// File: rtl/cnf_run_filter.sv
module cnf_run_filter #(
  parameter int unsigned MAX_RUN = 8,
  localparam int unsigned RUN_W  = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp,
  input  logic             smp_en,
  input  logic [RUN_W-1:0] run_n,
  output logic             level_q,
  output logic             level_d
);
  localparam logic [RUN_W-1:0] ONE = RUN_W'(1);

  logic [RUN_W-1:0] cnt_q, cnt_d;
  logic             differs;
  logic             done;

  always_comb begin
    differs = smp_en && (smp != level_q);
    done    = differs && ((cnt_q + ONE) >= run_n);
    level_d = level_q;
    cnt_d   = cnt_q;
    if (smp_en) begin
      if (!differs)  cnt_d = '0;
      else if (done) begin
        cnt_d   = '0;
        level_d = smp;
      end else       cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: without a sample enable the level may not move
  p_hold_without_sample_r3: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(level_q));
  // R8: the run count stays below the longest run
  p_count_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q < RUN_W'(MAX_RUN));
  // R4: a level change comes only at the end of a complete run
  p_change_after_run_r4: assert property (@(posedge clk) disable iff (rst)
    smp_en && (smp != level_q) && ((cnt_q + ONE) < run_n) |=> $stable(level_q));
  // R8: an agreeing sample clears the run
  p_agree_clears_r8: assert property (@(posedge clk) disable iff (rst)
    smp_en && (smp == level_q) |=> (cnt_q == '0));
endmodule

// File: rtl/cnf_edge_pulse.sv
module cnf_edge_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level_q,
  input  logic level_d,
  output logic rise_q,
  output logic fall_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= level_d && !level_q;
      fall_q <= !level_d && level_q;
    end
  end
endmodule

// File: rtl/capture_noise_filter.sv
module capture_noise_filter
  import cnf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CODE_W      = CNF_CODE_W,
  parameter int unsigned MAX_RUN     = CNF_MAX_RUN,
  localparam int unsigned RUN_W      = $clog2(MAX_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_async,
  input  logic              dts_tick,
  input  logic [CODE_W-1:0] flt_code,
  output logic              filt_level,
  output logic              rise_pulse,
  output logic              fall_pulse
);
  logic             smp;
  logic             smp_en;
  logic [RUN_W-1:0] run_n;
  logic             level_d;

  cnf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(din_async), .d_out(smp)
  );

  cnf_sample_ctrl #(.CODE_W(CODE_W), .MAX_RUN(MAX_RUN)) u_ctrl (
    .dts_tick(dts_tick), .code(flt_code), .smp_en(smp_en), .run_n(run_n)
  );

  cnf_run_filter #(.MAX_RUN(MAX_RUN)) u_filter (
    .clk(clk), .rst(rst), .smp(smp), .smp_en(smp_en), .run_n(run_n),
    .level_q(filt_level), .level_d(level_d)
  );

  cnf_edge_pulse u_edges (
    .clk(clk), .rst(rst), .level_q(filt_level), .level_d(level_d),
    .rise_q(rise_pulse), .fall_q(fall_pulse)
  );

  // R9: a rising strobe accompanies a fresh high level
  p_rise_marks_up_r9: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> (filt_level && !$past(filt_level)));
  // R10: a falling strobe accompanies a fresh low level
  p_fall_marks_down_r10: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |-> (!filt_level && $past(filt_level)));
  // R10: the two strobes are exclusive
  p_pulses_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_pulse, fall_pulse}));
  // R9: every level rise is flagged
  p_rise_flagged_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_level) |-> rise_pulse);
endmodule

// File: tb/test_capture_noise_filter.sv
module test_capture_noise_filter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din_async = 1'b0;
  logic       dts_tick = 1'b0;
  logic [3:0] flt_code = 4'd0;
  logic       filt_level, rise_pulse, fall_pulse;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    cmp_on   = 1'b0;
  bit    done     = 1'b0;

  // reference model state
  int m_hist[$];
  int m_level = 0;
  int m_cnt   = 0;
  int m_rise  = 0;
  int m_fall  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_noise_filter i_capture_noise_filter (
    .clk(clk), .rst(rst), .din_async(din_async), .dts_tick(dts_tick),
    .flt_code(flt_code), .filt_level(filt_level),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  function automatic int need_of(input logic [3:0] c);
    if (c == 4'd0) return 1;
    if (c == 4'd1) return 2;
    if (c == 4'd2) return 4;
    return 8;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hist = '{0, 0};
      m_level = 0; m_cnt = 0; m_rise = 0; m_fall = 0;
    end else begin
      int s;
      bit en;
      s = m_hist.pop_front();
      m_hist.push_back(int'(din_async));
      en = (flt_code == 4'd0) ? dts_tick : 1'b1;
      m_rise = 0; m_fall = 0;
      if (en) begin
        if (s != m_level) begin
          m_cnt++;
          if (m_cnt >= need_of(flt_code)) begin
            m_level = s;
            m_cnt = 0;
            if (s == 1) m_rise = 1; else m_fall = 1;
          end
        end else m_cnt = 0;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      check(cur_req, "filt_level", int'(filt_level), m_level);
      check("R9", "rise_pulse", int'(rise_pulse), m_rise);
      check("R10", "fall_pulse", int'(fall_pulse), m_fall);
    end
  end

  task automatic step(input logic d, input logic t);
    din_async = d;
    dts_tick  = t;
    @(negedge clk);
  endtask

  task automatic train(input int hi, input int lo, input int tick_every);
    for (int i = 0; i < hi + lo; i++)
      step(i < hi, (tick_every <= 1) ? 1'b1 : ((i % tick_every) == 0));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    din_async = 1'b1;
    dts_tick  = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state, even with the input high
    check("R1", "reset filt_level", int'(filt_level), 0);
    check("R1", "reset rise_pulse", int'(rise_pulse), 0);
    check("R1", "reset fall_pulse", int'(fall_pulse), 0);
    din_async = 1'b0;
    rst = 1'b0;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R2: two-flop latency with code 0 and a constant tick
    cur_req = "R2";
    flt_code = 4'd0;
    din_async = 1'b1;
    @(negedge clk);
    check("R2", "level one edge after change", int'(filt_level), 0);
    @(negedge clk);
    check("R2", "level two edges after change", int'(filt_level), 0);
    @(negedge clk);
    check("R2", "level three edges after change", int'(filt_level), 1);
    train(0, 6, 1);

    // R3: code 0 samples only on ticks
    cur_req = "R3";
    for (int w = 1; w < 8; w++) train(w, 5, 3);
    din_async = 1'b1; dts_tick = 1'b0;
    repeat (8) @(negedge clk);
    check("R3", "no tick keeps level", int'(filt_level), 0);
    train(0, 6, 2);

    // R4, R5, R6: widths around each run length
    cur_req = "R4";
    flt_code = 4'd1;
    for (int w = 1; w < 5; w++) train(w, w + 3, 1);
    cur_req = "R5";
    flt_code = 4'd2;
    for (int w = 2; w < 7; w++) train(w, w + 5, 1);
    cur_req = "R6";
    flt_code = 4'd3;
    for (int w = 6; w < 11; w++) train(w, w + 9, 1);
    train(7, 0, 1);
    check("R6", "seven samples not enough", int'(filt_level), 0);
    train(0, 12, 1);

    // R7: high codes act like code 3, tick ignored
    cur_req = "R7";
    for (int c = 4; c < 16; c++) begin
      flt_code = 4'(c);
      train(7, 9, 0);
      train(8, 12, 5);
      train(9, 12, 0);
    end

    // R8: a single agreeing sample restarts the run
    cur_req = "R8";
    flt_code = 4'd3;
    train(7, 1, 1);
    train(7, 0, 1);
    check("R8", "broken run kept level", int'(filt_level), 0);
    train(0, 10, 1);
    flt_code = 4'd2;
    train(3, 1, 1);
    train(3, 0, 1);
    check("R8", "broken run of four kept level", int'(filt_level), 0);
    train(0, 8, 1);

    // mixed random stretch, codes changing mid-run
    for (int i = 0; i < 3000; i++) begin
      if ((i % 37) == 0) flt_code = 4'($urandom_range(0, 15));
      if ((i % 3) == 0) din_async = (($urandom % 4) != 0) ? ~din_async : din_async;
      dts_tick = ($urandom % 2) == 1;
      @(negedge clk);
    end

    finish_run();
  end
endmodule